// File: doc/BRIEF.md
# Pin I/O Controller with Four-Way Per-Pin Interrupt Detection

This block drives and samples a bank of general-purpose pads under the control of a word-wide register interface with address, write data, write strobe and combinational read data. Each pin is configured by one bit in each control register. These controls cover:

- input sampling enable
- output drive enable and output value
- output polarity flip
- pull-up request and drive strength
- routing of one of two peripheral signals onto the pad in place of the register-driven value

Each pin can also raise an interrupt from four independent detectors: rising edge, falling edge, high level and low level. Each detector has its own enable bit and its own sticky pending bit. Software clears a pending bit by writing a one to it. The block has one interrupt output per pin, which is the OR of that pin's enabled pending bits. Pad inputs pass through a synchroniser chain before any detection or readback. Edges are found by comparing the synchronised value with its value one cycle earlier.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every control, enable and pending register reads 0, `pad_oe` and `pin_irq` are 0, and word addresses 17 to 31 read 0.
- R2: Word addresses are 0 input value (read-only), 1 sample enable, 2 drive enable, 3 drive value, 4 invert, 5 pull-up, 6 strength, 7 peripheral-route enable, 8 peripheral select, 9..12 enables for rise/fall/high/low, and 13..16 pending for rise/fall/high/low. A write takes effect at the clock edge where `bus_we` is high. Writes to address 0 and to addresses 17 to 31 change nothing.
- R3: Reading address 0 returns `pad_in` delayed by two flops, so a pad change shows up after the second rising edge. The value is returned whether or not sampling is enabled.
- R4: A rise pending bit sets when the synchronised pin goes from 0 to 1 while its rise enable is set. The bit first reads 1 after the third rising edge following the pad change.
- R5: A fall pending bit sets on a synchronised 1-to-0 transition while its fall enable is set.
- R6: A high (low) pending bit is set again on every cycle that the synchronised pin is 1 (0) and its enable is set. A clear therefore only sticks once the level is gone.
- R7: Writing to a pending address clears the bits written as 1 and leaves the bits written as 0 unchanged. A detection in the same cycle as a clear leaves the bit set. A pending bit never drops without a clear.
- R8: `pin_irq[n]` is 1 when any of pin n's four pending bits is set together with its matching enable.
- R9: With both rise and fall enabled on a pin, both edge directions are latched.
- R10: When routing is off, `pad_out` equals drive value XOR invert and `pad_oe` equals drive enable. Invert does not alter the value read at address 0.
- R11: When a pin's route-enable bit is 1, its pad value and pad enable come from the peripheral selected by its select bit: 0 picks `alt0_*` and 1 picks `alt1_*`. The invert bit is still applied to the value.
- R12: `pad_ie` equals sample enable, `pad_pue` equals pull-up AND sample enable, and `pad_ds` equals strength.
- R13: A pin whose sample enable is 0 sets none of its pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pad_in | input | 32 | Raw pad input levels |
| pad_out | output | 32 | Value driven to pads |
| pad_oe | output | 32 | Pad output enables |
| pad_ie | output | 32 | Pad input enables |
| pad_pue | output | 32 | Pad pull-up requests |
| pad_ds | output | 32 | Pad drive-strength selects |
| alt0_out | input | 32 | Peripheral 0 pad values |
| alt0_oe | input | 32 | Peripheral 0 pad enables |
| alt1_out | input | 32 | Peripheral 1 pad values |
| alt1_oe | input | 32 | Peripheral 1 pad enables |
| pin_irq | output | 32 | Per-pin interrupt lines |

## Verification
The hardest situation to reach is a clear write that lands on the same edge where a new edge detection fires. That requires the write strobe to be placed exactly three rising edges after the pad change. The directed sequence counts those edges explicitly. A long random phase follows, with sparse pad toggles and frequent clear writes, so that set/clear collisions and persistent levels under clearing also occur by chance. A behavioural model, built on a delay-line queue, is compared against every output on every cycle throughout.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   localparam int REG_AW   = 5;
   localparam int EV_NUM   = 4;
   localparam int NUM_REGS = 17;

   typedef enum logic [REG_AW-1:0] {
      RA_PAD_IN    = 5'd0,
      RA_SAMPLE_EN = 5'd1,
      RA_DRIVE_EN  = 5'd2,
      RA_DRIVE_VAL = 5'd3,
      RA_INVERT    = 5'd4,
      RA_PULLUP    = 5'd5,
      RA_STRENGTH  = 5'd6,
      RA_ALT_EN    = 5'd7,
      RA_ALT_SEL   = 5'd8,
      RA_RISE_EN   = 5'd9,
      RA_FALL_EN   = 5'd10,
      RA_HIGH_EN   = 5'd11,
      RA_LOW_EN    = 5'd12,
      RA_RISE_PND  = 5'd13,
      RA_FALL_PND  = 5'd14,
      RA_HIGH_PND  = 5'd15,
      RA_LOW_PND   = 5'd16
   } reg_addr_e;

   // detector kinds, index order matches enable/pending address order
   typedef enum logic [1:0] {
      EV_RISE = 2'd0,
      EV_FALL = 2'd1,
      EV_HIGH = 2'd2,
      EV_LOW  = 2'd3
   } evt_kind_e;

   localparam int EN_BASE  = 9;
   localparam int PND_BASE = 13;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int N      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q,
   output logic [N-1:0] q_prev
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must be at least 2");
   end

   // chain_q[STAGES-1] is the synchronised value, chain_q[STAGES] its previous cycle
   logic [STAGES:0][N-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= d;
         for (int i = 1; i <= STAGES; i++) begin
            chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign q      = chain_q[STAGES-1];
   assign q_prev = chain_q[STAGES];
endmodule

// File: rtl/gpio_pend_reg.sv
module gpio_pend_reg #(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] hit,
   input  logic         clr_we,
   input  logic [N-1:0] clr_mask,
   output logic [N-1:0] pend
);
   logic [N-1:0] pend_q;
   logic [N-1:0] clr_bits;

   assign clr_bits = clr_we ? clr_mask : '0;

   // a detection in the same cycle wins over a clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr_bits) | hit;
   end

   assign pend = pend_q;
endmodule

// File: rtl/gpio_pad_route.sv
module gpio_pad_route #(
   parameter int N = 32
) (
   input  logic [N-1:0] gpio_val,
   input  logic [N-1:0] gpio_oe,
   input  logic [N-1:0] invert,
   input  logic [N-1:0] alt_en,
   input  logic [N-1:0] alt_sel,
   input  logic [N-1:0] alt0_out,
   input  logic [N-1:0] alt0_oe,
   input  logic [N-1:0] alt1_out,
   input  logic [N-1:0] alt1_oe,
   output logic [N-1:0] pad_out,
   output logic [N-1:0] pad_oe
);
   for (genvar i = 0; i < N; i++) begin : g_pin
      logic src;
      logic oe;
      always_comb begin
         if (alt_en[i]) begin
            src = alt_sel[i] ? alt1_out[i] : alt0_out[i];
            oe  = alt_sel[i] ? alt1_oe[i]  : alt0_oe[i];
         end else begin
            src = gpio_val[i];
            oe  = gpio_oe[i];
         end
      end
      assign pad_out[i] = src ^ invert[i];
      assign pad_oe[i]  = oe;
   end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
   import gpio_irq_pkg::*;
#(
   parameter int NPINS       = 32,
   parameter int DW          = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   input  logic              bus_we,
   output logic [DW-1:0]     bus_rdata,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_oe,
   output logic [NPINS-1:0]  pad_ie,
   output logic [NPINS-1:0]  pad_pue,
   output logic [NPINS-1:0]  pad_ds,
   input  logic [NPINS-1:0]  alt0_out,
   input  logic [NPINS-1:0]  alt0_oe,
   input  logic [NPINS-1:0]  alt1_out,
   input  logic [NPINS-1:0]  alt1_oe,
   output logic [NPINS-1:0]  pin_irq
);
   if (NPINS < 1 || NPINS > DW) begin : g_bad_width
      $error("gpio_irq_ctrl: NPINS must be between 1 and DW");
   end
   if (NUM_REGS > (1 << REG_AW)) begin : g_bad_map
      $error("gpio_irq_ctrl: register map exceeds address space");
   end

   logic [NPINS-1:0] wr_bits;
   assign wr_bits = bus_wdata[NPINS-1:0];

   logic [NPINS-1:0] sample_en_q, drive_en_q, drive_val_q, invert_q;
   logic [NPINS-1:0] pullup_q, strength_q, alt_en_q, alt_sel_q;
   logic [EV_NUM-1:0][NPINS-1:0] evt_en_q;
   logic [EV_NUM-1:0][NPINS-1:0] evt_pnd;
   logic [EV_NUM-1:0][NPINS-1:0] evt_hit;
   logic [NPINS-1:0] in_sync, in_prev;

   // ---------------- control registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sample_en_q <= '0;
         drive_en_q  <= '0;
         drive_val_q <= '0;
         invert_q    <= '0;
         pullup_q    <= '0;
         strength_q  <= '0;
         alt_en_q    <= '0;
         alt_sel_q   <= '0;
         evt_en_q    <= '0;
      end else if (bus_we) begin
         case (bus_addr)
            RA_SAMPLE_EN: sample_en_q <= wr_bits;
            RA_DRIVE_EN:  drive_en_q  <= wr_bits;
            RA_DRIVE_VAL: drive_val_q <= wr_bits;
            RA_INVERT:    invert_q    <= wr_bits;
            RA_PULLUP:    pullup_q    <= wr_bits;
            RA_STRENGTH:  strength_q  <= wr_bits;
            RA_ALT_EN:    alt_en_q    <= wr_bits;
            RA_ALT_SEL:   alt_sel_q   <= wr_bits;
            default: begin
               for (int k = 0; k < EV_NUM; k++) begin
                  if (bus_addr == REG_AW'(EN_BASE + k)) evt_en_q[k] <= wr_bits;
               end
            end
         endcase
      end
   end

   // ---------------- input synchroniser ----------------
   gpio_in_sync #(.N(NPINS), .STAGES(SYNC_STAGES)) sync_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .d      (pad_in),
      .q      (in_sync),
      .q_prev (in_prev)
   );

   // ---------------- interrupt detectors ----------------
   for (genvar k = 0; k < EV_NUM; k++) begin : g_evt
      logic [NPINS-1:0] cond;
      logic             clr_we;
      case (evt_kind_e'(k))
         EV_RISE: begin : g_rise
            assign cond = in_sync & ~in_prev;
         end
         EV_FALL: begin : g_fall
            assign cond = ~in_sync & in_prev;
         end
         EV_HIGH: begin : g_high
            assign cond = in_sync;
         end
         default: begin : g_low
            assign cond = ~in_sync;
         end
      endcase

      assign evt_hit[k] = cond & sample_en_q & evt_en_q[k];
      assign clr_we     = bus_we && (bus_addr == REG_AW'(PND_BASE + k));

      gpio_pend_reg #(.N(NPINS)) pend_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .hit      (evt_hit[k]),
         .clr_we   (clr_we),
         .clr_mask (wr_bits),
         .pend     (evt_pnd[k])
      );
   end

   always_comb begin
      pin_irq = '0;
      for (int k = 0; k < EV_NUM; k++) begin
         pin_irq = pin_irq | (evt_pnd[k] & evt_en_q[k]);
      end
   end

   // ---------------- pad outputs ----------------
   gpio_pad_route #(.N(NPINS)) route_i (
      .gpio_val (drive_val_q),
      .gpio_oe  (drive_en_q),
      .invert   (invert_q),
      .alt_en   (alt_en_q),
      .alt_sel  (alt_sel_q),
      .alt0_out (alt0_out),
      .alt0_oe  (alt0_oe),
      .alt1_out (alt1_out),
      .alt1_oe  (alt1_oe),
      .pad_out  (pad_out),
      .pad_oe   (pad_oe)
   );

   assign pad_ie  = sample_en_q;
   assign pad_pue = pullup_q & sample_en_q;
   assign pad_ds  = strength_q;

   // ---------------- read mux ----------------
   logic [NPINS-1:0] rd_bits;
   always_comb begin
      rd_bits = '0;
      case (bus_addr)
         RA_PAD_IN:    rd_bits = in_sync;
         RA_SAMPLE_EN: rd_bits = sample_en_q;
         RA_DRIVE_EN:  rd_bits = drive_en_q;
         RA_DRIVE_VAL: rd_bits = drive_val_q;
         RA_INVERT:    rd_bits = invert_q;
         RA_PULLUP:    rd_bits = pullup_q;
         RA_STRENGTH:  rd_bits = strength_q;
         RA_ALT_EN:    rd_bits = alt_en_q;
         RA_ALT_SEL:   rd_bits = alt_sel_q;
         default: begin
            for (int k = 0; k < EV_NUM; k++) begin
               if (bus_addr == REG_AW'(EN_BASE + k))  rd_bits = evt_en_q[k];
               if (bus_addr == REG_AW'(PND_BASE + k)) rd_bits = evt_pnd[k];
            end
         end
      endcase
   end
   assign bus_rdata = DW'(rd_bits);
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
   import gpio_irq_pkg::*;
#(
   parameter int NPINS = 32
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         bus_we,
   input logic [REG_AW-1:0]            bus_addr,
   input logic [NPINS-1:0]             wr_bits,
   input logic [NPINS-1:0]             sample_en,
   input logic [EV_NUM-1:0][NPINS-1:0] evt_en,
   input logic [EV_NUM-1:0][NPINS-1:0] evt_pnd,
   input logic [EV_NUM-1:0][NPINS-1:0] evt_hit,
   input logic [NPINS-1:0]             pin_irq,
   input logic [NPINS-1:0]             pad_ie,
   input logic [NPINS-1:0]             pad_pue
);
   for (genvar k = 0; k < EV_NUM; k++) begin : g_ev
      AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
         ((evt_pnd[k] & ~$past(evt_pnd[k]) & ~$past(evt_en[k])) == '0))
         else $error("pending bit rose with its enable clear"); // R4

      AST_PEND_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
         ((evt_pnd[k] & ~$past(evt_pnd[k]) & ~$past(sample_en)) == '0))
         else $error("pending bit rose on an unsampled pin"); // R13

      AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
         $past(bus_we && bus_addr == REG_AW'(PND_BASE + k)) |->
         ((evt_pnd[k] & $past(wr_bits) & ~$past(evt_hit[k])) == '0))
         else $error("write-one clear did not take effect"); // R7

      AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(bus_we && bus_addr == REG_AW'(PND_BASE + k)) |->
         (($past(evt_pnd[k]) & ~evt_pnd[k]) == '0))
         else $error("pending bit dropped without a clear"); // R7
   end

   AST_IRQ_HAS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_irq & ~(evt_pnd[0] | evt_pnd[1] | evt_pnd[2] | evt_pnd[3])) == '0))
      else $error("interrupt line with no pending source"); // R8

   AST_PULLUP_ON_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_pue & ~pad_ie) == '0))
      else $error("pull-up requested on a non-sampled pin"); // R12
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .wr_bits   (wr_bits),
   .sample_en (sample_en_q),
   .evt_en    (evt_en_q),
   .evt_pnd   (evt_pnd),
   .evt_hit   (evt_hit),
   .pin_irq   (pin_irq),
   .pad_ie    (pad_ie),
   .pad_pue   (pad_pue)
);

// File: tb/gpio_irq_ctrl_tb_top.sv
module gpio_irq_ctrl_tb_top;
   import gpio_irq_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_rdata;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_out, pad_oe, pad_ie, pad_pue, pad_ds, pin_irq;
   logic [31:0] alt0_out = '0, alt0_oe = '0, alt1_out = '0, alt1_oe = '0;

   always #2 clk = ~clk;   // 250 MHz

   gpio_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .pad_ie(pad_ie), .pad_pue(pad_pue),
      .pad_ds(pad_ds), .alt0_out(alt0_out), .alt0_oe(alt0_oe),
      .alt1_out(alt1_out), .alt1_oe(alt1_oe), .pin_irq(pin_irq)
   );

   int n_chk = 0;
   int n_err = 0;
   bit started = 0;
   bit done = 0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference ----------------
   logic [31:0] m_reg [0:31];
   logic [31:0] m_hist [$];       // pad samples, newest first
   logic [31:0] m_nxt [0:3];
   logic [31:0] m_s, m_p, m_set, m_clr;

   initial begin
      for (int a = 0; a < 32; a++) m_reg[a] = '0;
      m_hist = '{32'h0, 32'h0, 32'h0};
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int a = 0; a < 32; a++) m_reg[a] = '0;
         m_hist = '{32'h0, 32'h0, 32'h0};
      end else begin
         m_s = m_hist[1];
         m_p = m_hist[2];
         for (int k = 0; k < 4; k++) begin
            case (k)
               0:       m_set = m_s & ~m_p;
               1:       m_set = ~m_s & m_p;
               2:       m_set = m_s;
               default: m_set = ~m_s;
            endcase
            m_set = m_set & m_reg[1] & m_reg[9+k];
            m_clr = (bus_we && int'(bus_addr) == 13 + k) ? bus_wdata : 32'h0;
            m_nxt[k] = (m_reg[13+k] & ~m_clr) | m_set;
         end
         if (bus_we && int'(bus_addr) >= 1 && int'(bus_addr) <= 12)
            m_reg[bus_addr] = bus_wdata;
         for (int k = 0; k < 4; k++) m_reg[13+k] = m_nxt[k];
         m_hist.push_front(pad_in);
         void'(m_hist.pop_back());
      end
      started = 1;
   end

   function automatic logic [31:0] m_read(int a);
      if (a == 0) return m_hist[1];
      if (a >= 1 && a <= 16) return m_reg[a];
      return 32'h0;
   endfunction

   function automatic logic [31:0] m_irq();
      logic [31:0] r = '0;
      for (int k = 0; k < 4; k++) r = r | (m_reg[13+k] & m_reg[9+k]);
      return r;
   endfunction

   function automatic logic [31:0] m_pad_out();
      logic [31:0] sel_out;
      sel_out = (m_reg[8] & alt1_out) | (~m_reg[8] & alt0_out);
      return ((m_reg[7] & sel_out) | (~m_reg[7] & m_reg[3])) ^ m_reg[4];
   endfunction

   function automatic logic [31:0] m_pad_oe();
      logic [31:0] sel_oe;
      sel_oe = (m_reg[8] & alt1_oe) | (~m_reg[8] & alt0_oe);
      return (m_reg[7] & sel_oe) | (~m_reg[7] & m_reg[2]);
   endfunction

   always @(negedge clk) begin
      if (started && !done) begin
         chk("R2 rdata",          bus_rdata, m_read(int'(bus_addr)));
         chk("R8 pin_irq",        pin_irq,   m_irq());
         chk("R10 R11 pad_out",   pad_out,   m_pad_out());
         chk("R10 R11 pad_oe",    pad_oe,    m_pad_oe());
         chk("R12 pad_ie",        pad_ie,    m_reg[1]);
         chk("R12 pad_pue",       pad_pue,   m_reg[5] & m_reg[1]);
         chk("R12 pad_ds",        pad_ds,    m_reg[6]);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic idle(int n);
      repeat (n) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic wr(int a, logic [31:0] d);
      bus_we    = 1'b1;
      bus_addr  = 5'(a);
      bus_wdata = d;
      @(posedge clk);
      #1;
      bus_we    = 1'b0;
   endtask

   task automatic rd_chk(int a, logic [31:0] exp, string tag);
      bus_addr = 5'(a);
      @(negedge clk);
      chk(tag, bus_rdata, exp);
      @(posedge clk);
      #1;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog act=running exp=finished");
         summary();
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state on every address
      for (int a = 0; a < 32; a++) rd_chk(a, 32'h0, "R1 reset read");
      @(negedge clk);
      chk("R1 pad_oe", pad_oe, 32'h0);
      chk("R1 pin_irq", pin_irq, 32'h0);
      idle(1);

      // detector configuration
      wr(RA_SAMPLE_EN, 32'h0000_00FF);
      wr(RA_RISE_EN,   32'h0000_0011);
      wr(RA_FALL_EN,   32'h0000_0012);
      wr(RA_HIGH_EN,   32'h0000_0004);
      wr(RA_LOW_EN,    32'h0000_0008);
      idle(2);
      rd_chk(RA_LOW_PND, 32'h8, "R6 low level latched");

      pad_in = 32'h0000_001F;
      idle(4);
      rd_chk(RA_RISE_PND, 32'h11, "R4 rise pending");
      rd_chk(RA_HIGH_PND, 32'h04, "R6 high pending");
      rd_chk(RA_FALL_PND, 32'h00, "R5 no fall yet");
      @(negedge clk);
      chk("R8 irq lines", pin_irq, 32'h1D);
      idle(1);

      pad_in = 32'h0;
      idle(4);
      rd_chk(RA_FALL_PND, 32'h12, "R5 fall pending");
      rd_chk(RA_RISE_PND, 32'h11, "R9 double edge keeps rise");

      wr(RA_RISE_PND, 32'h01);
      rd_chk(RA_RISE_PND, 32'h10, "R7 clear one bit only");
      wr(RA_RISE_PND, 32'h10);
      rd_chk(RA_RISE_PND, 32'h00, "R7 cleared");
      wr(RA_HIGH_PND, 32'h04);
      rd_chk(RA_HIGH_PND, 32'h00, "R6 high clear after level gone");
      wr(RA_LOW_PND, 32'h08);
      rd_chk(RA_LOW_PND, 32'h08, "R6 low clear while level persists");

      // set beats clear: detection lands on the third edge after the pad change
      pad_in = 32'h0000_0001;
      idle(2);
      wr(RA_RISE_PND, 32'h01);
      rd_chk(RA_RISE_PND, 32'h01, "R7 set wins over clear");

      // unsampled pin 8 with rise enable set
      wr(RA_RISE_EN, 32'h0000_0111);
      pad_in = 32'h0000_0101;
      idle(4);
      rd_chk(RA_RISE_PND, 32'h01, "R13 unsampled pin ignored");
      rd_chk(RA_PAD_IN, 32'h0000_0101, "R3 unsampled pin still readable");

      // synchroniser latency
      pad_in = 32'h0000_0103;
      idle(1);
      rd_chk(RA_PAD_IN, 32'h0000_0101, "R3 one edge old value");
      rd_chk(RA_PAD_IN, 32'h0000_0103, "R3 two edges new value");

      // driven outputs and inversion
      wr(RA_DRIVE_EN,  32'h000F_0000);
      wr(RA_DRIVE_VAL, 32'h0003_0000);
      wr(RA_INVERT,    32'h0005_0000);
      pad_in = 32'h0001_0103;
      idle(3);
      @(negedge clk);
      chk("R10 pad_out inverted", pad_out & 32'h000F_0000, 32'h0006_0000);
      chk("R10 pad_oe", pad_oe, 32'h000F_0000);
      idle(1);
      rd_chk(RA_PAD_IN, 32'h0001_0103, "R10 invert leaves input");

      // peripheral routing
      alt0_out = '1; alt0_oe = '1; alt1_out = '0; alt1_oe = '1;
      wr(RA_ALT_EN,  32'h0030_0000);
      wr(RA_ALT_SEL, 32'h0020_0000);
      @(negedge clk);
      chk("R11 routed value", pad_out & 32'h0030_0000, 32'h0010_0000);
      chk("R11 routed enable", pad_oe & 32'h0030_0000, 32'h0030_0000);
      idle(1);

      // pad controls
      wr(RA_PULLUP,   32'h0000_01FF);
      wr(RA_STRENGTH, 32'h0000_ABCD);
      @(negedge clk);
      chk("R12 pull-up gated", pad_pue, 32'h0000_00FF);
      chk("R12 strength", pad_ds, 32'h0000_ABCD);
      idle(1);

      // ignored writes
      wr(RA_PAD_IN, 32'hFFFF_FFFF);
      rd_chk(RA_PAD_IN, 32'h0001_0103, "R2 input value read-only");
      wr(20, 32'hFFFF_FFFF);
      rd_chk(20, 32'h0, "R2 unmapped write");
      rd_chk(RA_SAMPLE_EN, 32'h0000_00FF, "R2 unmapped write no alias");

      // random phase, compared cycle by cycle against the reference
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(0, 3) == 0) pad_in = pad_in ^ ($urandom & $urandom);
         bus_we    = ($urandom_range(0, 2) == 0);
         bus_addr  = 5'($urandom_range(0, 20));
         bus_wdata = ($urandom_range(0, 1) == 0) ? 32'hFFFF_FFFF : $urandom;
         if ($urandom_range(0, 15) == 0) begin
            alt0_out = $urandom; alt1_out = $urandom;
            alt0_oe  = $urandom; alt1_oe  = $urandom;
         end
         @(posedge clk);
         #1;
      end
      bus_we = 1'b0;
      idle(2);

      done = 1;
      summary();
      $finish;
   end
endmodule